// File: doc/BRIEF.md
# Handshaked Fixed-Latency Working Memory

This block is a single-port working memory for one requester on one clock. A request carries a word address, a 78-bit write word made of two 39-bit halfwords with one enable each, and a write/read select. The requester raises `req_valid` and holds it until the memory raises `req_ack`. A request is accepted only in a cycle where both are high.

A write updates only the halfwords whose enables are set and produces no response. A read returns the stored word on `rsp_data`, with `rsp_valid` high, exactly `RD_LAT` cycles after it was accepted. One request can be accepted per cycle, and back-to-back reads come back in the order they were accepted.

A small handshake machine controls acknowledge and has two states. `ST_WAKE` is entered on reset and lasts one cycle, during which acknowledge stays low. Its transition `wake_done` always leads to `ST_SERVE`. In `ST_SERVE` acknowledge follows valid in the same cycle, and the state holds itself through the transition `serve_hold`.

Top module: `wkmem_responder`

## Requirements
- R1: While reset is asserted, `rsp_valid` is low. In the first cycle after reset is released, the machine is in `ST_WAKE` and `req_ack` is low even if `req_valid` is high.
- R2: In `ST_SERVE`, `req_ack` equals `req_valid` in the same cycle. `req_ack` is never high while `req_valid` is low.
- R3: A request held on `req_valid` through the `ST_WAKE` cycle is acknowledged, and accepted exactly once, in the following cycle.
- R4: On an accepted write (`req_we`=1), `req_hen[0]` governs data bits 38:0 and `req_hen[1]` governs bits 77:39. A halfword whose enable is 0 keeps its previous contents.
- R5: A read (`req_we`=0) accepted in cycle c drives `rsp_valid`=1 in cycle c+`RD_LAT`. In that cycle `rsp_data` holds the word as written by every write accepted before cycle c.
- R6: An accepted write never raises `rsp_valid`. `rsp_valid` is high only for reads, and no more than `RD_LAT` reads are outstanding at any time.
- R7: Reads accepted in consecutive cycles return in consecutive cycles, in the order they were accepted.
- R8: Only the low log2(`DEPTH`) address bits select a word; the upper address bits are ignored, so addresses that differ only in those bits reach the same word.
- R9: The behaviour of R5 to R7 holds for any `RD_LAT` of at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_ack | output | 1 | Request accepted this cycle |
| req_addr | input | 13 | Word address |
| req_wdata | input | 78 | Write word (two 39-bit halfwords) |
| req_hen | input | 2 | Halfword write enables (bit 0: 38:0, bit 1: 77:39) |
| req_we | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Read data present this cycle |
| rsp_data | output | 78 | Returned read word |

## Verification
The assertions assume that the requester keeps `req_valid` high after any cycle where it is not acknowledged. The bench meets this by holding its first request through the wake cycle; after that, acknowledge follows valid, so no request is ever left pending. The in-flight read count in the checker also assumes that reset clears the response pipeline. The bench applies reset only once, before any traffic, and drives every address it reads with a full write first, so no returned word is undefined.

// File: rtl/wkmem_pkg.sv
package wkmem_pkg;

    // Handshake machine states
    typedef enum logic [0:0] {
        ST_WAKE  = 1'b0,
        ST_SERVE = 1'b1
    } hs_state_e;

    localparam int NUM_HALVES = 2;

endpackage

// File: rtl/wkmem_handshake.sv
module wkmem_handshake
    import wkmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_we,
    output logic req_ack,
    output logic acc_rd,
    output logic acc_wr
);

    hs_state_e state_q;
    hs_state_e state_d;

    // Next-state logic: wake_done and serve_hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAKE:  state_d = ST_SERVE;
            ST_SERVE: state_d = ST_SERVE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        req_ack = 1'b0;
        unique case (state_q)
            ST_WAKE:  req_ack = 1'b0;
            ST_SERVE: req_ack = req_valid;
        endcase
        acc_rd = req_ack & ~req_we;
        acc_wr = req_ack &  req_we;
    end

endmodule

// File: rtl/wkmem_array.sv
module wkmem_array
    import wkmem_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int HALF_W = 39,
    parameter int DEPTH  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NUM_HALVES*HALF_W-1:0] wdata,
    input  logic [NUM_HALVES-1:0]        hen,
    output logic                         rd_vld,
    output logic [NUM_HALVES*HALF_W-1:0] rd_word
);

    localparam int DW    = NUM_HALVES * HALF_W;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0]    mem [DEPTH];
    logic [IDX_W-1:0] idx;

    assign idx = addr[IDX_W-1:0];

    // Upper address bits alias onto the same words
    logic addr_unused_hi;
    assign addr_unused_hi = ^addr[ADDR_W-1:IDX_W];

    // Halfword-masked write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int h = 0; h < NUM_HALVES; h++) begin
                if (hen[h]) begin
                    mem[idx][h*HALF_W +: HALF_W] <= wdata[h*HALF_W +: HALF_W];
                end
            end
        end
    end

    // Registered read: first stage of the return latency
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= mem[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= rd_en;
        end
    end

endmodule

// File: rtl/wkmem_rdpipe.sv
module wkmem_rdpipe #(
    parameter int DW    = 78,
    parameter int EXTRA = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_dat,
    output logic          out_vld,
    output logic [DW-1:0] out_dat
);

    generate
        if (EXTRA == 0) begin : g_pass
            assign out_vld = in_vld;
            assign out_dat = in_dat;
        end else begin : g_chain
            logic [EXTRA-1:0]         vld_q;
            logic [EXTRA-1:0][DW-1:0] dat_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q <= '0;
                end else begin
                    vld_q[0] <= in_vld;
                    for (int i = 1; i < EXTRA; i++) begin
                        vld_q[i] <= vld_q[i-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                dat_q[0] <= in_dat;
                for (int i = 1; i < EXTRA; i++) begin
                    dat_q[i] <= dat_q[i-1];
                end
            end

            assign out_vld = vld_q[EXTRA-1];
            assign out_dat = dat_q[EXTRA-1];
        end
    endgenerate

endmodule

// File: rtl/wkmem_responder.sv
module wkmem_responder
    import wkmem_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int HALF_W = 39,
    parameter int DEPTH  = 64,
    parameter int RD_LAT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ack,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [NUM_HALVES*HALF_W-1:0] req_wdata,
    input  logic [NUM_HALVES-1:0]        req_hen,
    input  logic                         req_we,
    output logic                         rsp_valid,
    output logic [NUM_HALVES*HALF_W-1:0] rsp_data
);

    localparam int DW    = NUM_HALVES * HALF_W;
    localparam int EXTRA = (RD_LAT > 1) ? RD_LAT - 1 : 0;

    logic          acc_rd;
    logic          acc_wr;
    logic          arr_vld;
    logic [DW-1:0] arr_word;

    wkmem_handshake u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_ack   (req_ack),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr)
    );

    wkmem_array #(
        .ADDR_W (ADDR_W),
        .HALF_W (HALF_W),
        .DEPTH  (DEPTH)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_wr),
        .rd_en   (acc_rd),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .hen     (req_hen),
        .rd_vld  (arr_vld),
        .rd_word (arr_word)
    );

    wkmem_rdpipe #(
        .DW    (DW),
        .EXTRA (EXTRA)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (arr_vld),
        .in_dat  (arr_word),
        .out_vld (rsp_valid),
        .out_dat (rsp_data)
    );

endmodule

// File: rtl/wkmem_responder_chk.sv
module wkmem_responder_chk #(
    parameter int RD_LAT = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ack,
    input logic req_we,
    input logic rsp_valid
);

    localparam int CW = $clog2(RD_LAT + 2) + 1;

    logic          up_q;
    logic [CW-1:0] inflight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q       <= 1'b0;
            inflight_q <= '0;
        end else begin
            up_q       <= 1'b1;
            inflight_q <= inflight_q
                        + CW'(req_valid && req_ack && !req_we)
                        - CW'(rsp_valid);
        end
    end

    // R1: no acknowledge in the wake cycle
    assert_wake_no_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !up_q |-> !req_ack);

    // R2: acknowledge follows valid once serving
    assert_ack_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && req_valid) |-> req_ack);

    // R2: no acknowledge without a request
    assert_no_ack_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> req_valid);

    // R3: an unacknowledged request stays up
    assert_hold_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> req_valid);

    // R6: responses only for outstanding reads
    assert_no_spurious_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (inflight_q != '0));

    // R6: outstanding reads bounded by the latency
    assert_inflight_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CW'(RD_LAT));

endmodule

bind wkmem_responder wkmem_responder_chk #(.RD_LAT(RD_LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_we    (req_we),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_wkmem_responder.sv
`timescale 1ns/1ps
module tb_wkmem_responder;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [12:0] req_addr = '0;
    logic [77:0] req_wdata = '0;
    logic [1:0]  req_hen = '0;

    logic        ack [3];
    logic        rv  [3];
    logic [77:0] rd  [3];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lat [3] = '{3, 1, 5};
    bit done = 1'b0;

    logic [77:0] mdl [DEPTH];
    bit          ex_v [3][8];
    logic [77:0] ex_d [3][8];
    string       ex_t [3][8];

    always #10 clk = ~clk;

    // Main instance plus two more latencies for R9
    wkmem_responder #(.RD_LAT(3)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(ack[0]),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_hen(req_hen),
        .req_we(req_we), .rsp_valid(rv[0]), .rsp_data(rd[0]));
    wkmem_responder #(.RD_LAT(1)) dut_l1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(ack[1]),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_hen(req_hen),
        .req_we(req_we), .rsp_valid(rv[1]), .rsp_data(rd[1]));
    wkmem_responder #(.RD_LAT(5)) dut_l5 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(ack[2]),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_hen(req_hen),
        .req_we(req_we), .rsp_valid(rv[2]), .rsp_data(rd[2]));

    function automatic logic [77:0] rnd78();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[77:0];
    endfunction

    task automatic check_rsp();
        for (int k = 0; k < 3; k++) begin
            int    s;
            string tg;
            s  = cyc % 8;
            tg = ex_v[k][s] ? ex_t[k][s] : "R6";
            if (k != 0) tg = {"R9 ", tg};
            total++;
            if (rv[k] !== ex_v[k][s]) begin
                bad++;
                $display("FAIL %s lat=%0d cyc=%0d rsp_valid got=%0b expected=%0b",
                         tg, lat[k], cyc, rv[k], ex_v[k][s]);
            end else if (ex_v[k][s] && rd[k] !== ex_d[k][s]) begin
                bad++;
                $display("FAIL %s lat=%0d cyc=%0d rsp_data got=%h expected=%h",
                         tg, lat[k], cyc, rd[k], ex_d[k][s]);
            end
            ex_v[k][s] = 1'b0;
        end
    endtask

    task automatic step(input bit v, input bit we, input logic [12:0] a,
                        input logic [77:0] d, input logic [1:0] h,
                        input string tag, input bit release_rst);
        bit exp_ack;
        int ix;
        @(negedge clk);
        cyc++;
        check_rsp();
        if (release_rst) rst_n = 1'b1;
        req_valid = v; req_we = we; req_addr = a; req_wdata = d; req_hen = h;
        #1;
        exp_ack = v && !release_rst;
        for (int k = 0; k < 3; k++) begin
            total++;
            if (ack[k] !== exp_ack) begin
                bad++;
                $display("FAIL %s lat=%0d cyc=%0d req_ack got=%0b expected=%0b",
                         release_rst ? "R1" : tag, lat[k], cyc, ack[k], exp_ack);
            end
        end
        ix = int'(a) % DEPTH;
        if (exp_ack) begin
            if (we) begin
                if (h[0]) mdl[ix][38:0]  = d[38:0];
                if (h[1]) mdl[ix][77:39] = d[77:39];
            end else begin
                for (int k = 0; k < 3; k++) begin
                    int s;
                    s = (cyc + lat[k]) % 8;
                    ex_v[k][s] = 1'b1;
                    ex_d[k][s] = mdl[ix];
                    ex_t[k][s] = tag;
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, "R6", 1'b0);
    endtask

    initial begin
        logic [77:0] w;
        for (int k = 0; k < 3; k++)
            for (int s = 0; s < 8; s++) ex_v[k][s] = 1'b0;

        // R1: reset holds the response output low
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            total++;
            if (rv[k] !== 1'b0) begin
                bad++;
                $display("FAIL R1 lat=%0d reset rsp_valid got=%0b expected=0", lat[k], rv[k]);
            end
        end

        // R1 wake cycle, then R3: same request accepted next cycle
        w = rnd78();
        step(1'b1, 1'b1, 13'd0, w, 2'b11, "R1", 1'b1);
        step(1'b1, 1'b1, 13'd0, w, 2'b11, "R3", 1'b0);

        // Fill every word with a full write
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 1'b1, 13'(i), rnd78(), 2'b11, "R5", 1'b0);

        // R4: halfword masking
        step(1'b1, 1'b1, 13'd7, rnd78(), 2'b11, "R4", 1'b0);
        step(1'b1, 1'b1, 13'd7, rnd78(), 2'b01, "R4", 1'b0);
        step(1'b1, 1'b0, 13'd7, '0, '0, "R4", 1'b0);
        step(1'b1, 1'b1, 13'd7, rnd78(), 2'b10, "R4", 1'b0);
        step(1'b1, 1'b0, 13'd7, '0, '0, "R4", 1'b0);
        step(1'b1, 1'b1, 13'd7, rnd78(), 2'b00, "R4", 1'b0);
        step(1'b1, 1'b0, 13'd7, '0, '0, "R4", 1'b0);
        idle(6);

        // R7: back-to-back reads return in order
        for (int i = 0; i < 12; i++)
            step(1'b1, 1'b0, 13'(i * 5), '0, '0, "R7", 1'b0);
        idle(6);

        // R8: upper address bits alias
        step(1'b1, 1'b1, 13'd73, rnd78(), 2'b11, "R8", 1'b0);
        step(1'b1, 1'b0, 13'd9, '0, '0, "R8", 1'b0);
        step(1'b1, 1'b1, 13'd9, rnd78(), 2'b11, "R8", 1'b0);
        step(1'b1, 1'b0, 13'd4105, '0, '0, "R8", 1'b0);
        idle(6);

        // R6: a burst of writes raises no response
        for (int i = 0; i < 10; i++)
            step(1'b1, 1'b1, 13'(i), rnd78(), 2'($urandom_range(3)), "R6", 1'b0);
        idle(6);

        // R5: random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            bit v;
            bit we;
            v  = ($urandom_range(9) < 7);
            we = ($urandom_range(9) < 4);
            step(v, we, 13'($urandom_range(8191)), rnd78(),
                 2'($urandom_range(3)), "R5", 1'b0);
        end
        idle(8);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule